// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder

This block recovers the information stream of a rate-1/2 convolutional code from hard-decision received bit pairs. Each accepted pair advances the trellis by one stage. For every one of the 2^(K-1) states, the block adds a Hamming branch metric to the path metric of each of the two possible predecessor states and keeps the smaller sum. It then rebases all metrics on the stage minimum and stores one decision bit per state in a circular survivor memory that is 5*K stages deep.

When the memory is full, every new stage starts a traceback. The traceback begins at the state with the lowest metric and follows the stored decisions back through the window. The input bit implied at the oldest stage of the window is released as the decoded bit. The decoder therefore runs as a continuous sliding window, with one output bit per stage and a fixed delay of 5*K stages.

The sender sets the encoder register to all zeros before the first bit. The receiver offers pairs on a valid/ready handshake. The decoded bits come out in the same order as the information bits went into the encoder.

Top module: `hd_viterbi_dec`

## Requirements
- R1: After reset, sym_ready is 1 and bit_valid is 0. The decoder assumes the encoder started in the all-zero state. No decoded bit appears before 5*K pairs have been accepted.
- R2: The code is defined as follows. With encoder state s, where s[K-2] is the most recent bit, and input u, the register is r = {u, s}. The next state is r[K-1:1]. sym[0] is the parity of r & G0 and sym[1] is the parity of r & G1, with defaults K=7, G0=octal 171 and G1=octal 133. For error-free pairs, the decoded stream equals the encoded bit stream, in order.
- R3: Path metrics are rebased on the stage minimum after every stage. This keeps the minimum metric at 0 and every metric below 2^(PMW-1), so decoding stays correct over arbitrarily long streams.
- R4: Branch metrics are Hamming distances. An isolated flipped received bit, with at least 40 pairs to the next flip, is corrected.
- R5: Once the window is full, each accepted pair yields exactly one decoded bit. The k-th decoded bit is the k-th encoded bit, so N accepted pairs yield N-5*K+1 bits.
- R6: After a pair is accepted with the window full, sym_ready is 0 for exactly 5*K cycles. bit_valid is then high for one cycle, in the same cycle that sym_ready returns to 1.
- R7: sym_valid and sym are ignored while sym_ready is 0. Metrics and survivors change only on an accepted pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A received pair is offered |
| sym_ready | output | 1 | The decoder can accept a pair this cycle |
| sym | input | 2 | Received pair: bit 0 for G0, bit 1 for G1 |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_out | output | 1 | Decoded information bit |

## Verification
The bench predicts sym_ready and bit_valid on every cycle. A decoder that starts output one stage early or late, or that stalls for the wrong number of cycles, therefore fails at once. During the stall it drives garbage pairs with sym_valid high; a decoder that takes them would corrupt later output bits. It also runs all-ones and alternating streams, streams with isolated errors, and one stream longer than 600 stages. A wrong predecessor convention, a wrong traceback start state or missing metric rebasing would corrupt the decoded bits or lose them once the metrics wrap.

// File: rtl/hd_viterbi_dec.sv
module hd_viterbi_dec #(
  parameter int K = 7,
  parameter logic [K-1:0] G0 = 'o171,
  parameter logic [K-1:0] G1 = 'o133,
  parameter int PMW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_valid,
  output logic       sym_ready,
  input  logic [1:0] sym,
  output logic       bit_valid,
  output logic       bit_out
);
  localparam int SW = K - 1;
  localparam int NS = 1 << SW;
  localparam int DEPTH = 5 * K;
  localparam int PW = $clog2(DEPTH);
  localparam logic [PMW-1:0] INIT = PMW'(1) << (PMW - 2);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [NS-1:0][PMW-1:0] pm, raw;
  logic [NS-1:0]          dec;
  logic [NS-1:0]          surv [DEPTH];
  logic [PMW-1:0]         mn;
  logic [SW-1:0]          bs, st;
  logic [PW-1:0]          wp, rp, fill, tbc;
  logic                   busy;

  assign sym_ready = !busy;
  wire take = sym_valid && !busy;

  function automatic logic [1:0] enc(input logic [K-1:0] r);
    return {^(r & G1), ^(r & G0)};
  endfunction

  function automatic logic [1:0] hd2(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return {1'b0, x[1]} + {1'b0, x[0]};
  endfunction

  always_comb begin : acs
    logic [SW-1:0]  nx, q0, q1;
    logic [PMW-1:0] c0, c1;
    for (int n = 0; n < NS; n++) begin
      nx = SW'(n);
      q0 = {nx[SW-2:0], 1'b0};
      q1 = {nx[SW-2:0], 1'b1};
      c0 = pm[q0] + PMW'(hd2(enc({nx[SW-1], q0}), sym));
      c1 = pm[q1] + PMW'(hd2(enc({nx[SW-1], q1}), sym));
      dec[n] = c1 < c0;
      raw[n] = (c1 < c0) ? c1 : c0;
    end
  end

  always_comb begin : best
    mn = raw[0];
    bs = '0;
    for (int n = 1; n < NS; n++)
      if (raw[n] < mn) begin
        mn = raw[n];
        bs = SW'(n);
      end
  end

  always_ff @(posedge clk)
    if (take) surv[wp] <= dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NS; n++) pm[n] <= (n == 0) ? '0 : INIT;
      busy <= 1'b0;
      wp <= '0;
      rp <= '0;
      fill <= '0;
      tbc <= '0;
      st <= '0;
      bit_valid <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (!busy) begin
        if (sym_valid) begin
          for (int n = 0; n < NS; n++) pm[n] <= raw[n] - mn;
          wp <= (wp == LAST) ? '0 : wp + 1'b1;
          rp <= wp;
          st <= bs;
          if (fill == LAST) begin
            busy <= 1'b1;
            tbc <= LAST;
          end else begin
            fill <= fill + 1'b1;
          end
        end
      end else if (tbc == '0) begin
        busy <= 1'b0;
        bit_valid <= 1'b1;
        bit_out <= st[SW-1];
      end else begin
        st <= {st[SW-2:0], surv[rp][st]};
        rp <= (rp == '0) ? LAST : rp - 1'b1;
        tbc <= tbc - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hd_vit_chk.sv
module hd_vit_chk #(
  parameter int NS = 64,
  parameter int PMW = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                sym_valid,
  input logic                sym_ready,
  input logic                bit_valid,
  input logic [NS*PMW-1:0]   pm
);
  logic any_zero, all_low;

  always_comb begin
    any_zero = 1'b0;
    all_low = 1'b1;
    for (int n = 0; n < NS; n++) begin
      if (pm[n*PMW +: PMW] == '0) any_zero = 1'b1;
      if (pm[n*PMW + PMW - 1]) all_low = 1'b0;
    end
  end

  p_min_zero_r3: assert property (@(posedge clk) disable iff (rst) any_zero);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst) all_low);
  p_metric_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(sym_valid && sym_ready) |=> $stable(pm));
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);
  p_valid_ready_r6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> sym_ready);
  p_stall_before_out_r6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(!sym_ready));
endmodule

bind hd_viterbi_dec hd_vit_chk #(.NS(NS), .PMW(PMW)) u_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .bit_valid(bit_valid), .pm(pm)
);

// File: tb/tb_hd_viterbi_dec.sv
module tb_hd_viterbi_dec;
  localparam int K = 7;
  localparam int DEPTH = 5 * K;
  localparam int GA = 'o171;
  localparam int GB = 'o133;

  logic clk = 1'b0, rst = 1'b1, sym_valid = 1'b0, sym_ready, bit_valid, bit_out;
  logic [1:0] sym = 2'b00;

  always #5 clk = ~clk;

  hd_viterbi_dec dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym(sym), .bit_valid(bit_valid), .bit_out(bit_out)
  );

  int checks = 0, errors = 0, cycles = 0;
  int busy_m = 0, nacc = 0, nout = 0, es = 0;
  bit vexp = 1'b0, wd = 1'b0;
  bit expq[$];
  string req = "R2";

  task automatic check(input bit ok, input string r, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", r, act, exp_v, cycles);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] s);
    bit e;
    check(sym_ready == (busy_m == 0), "R6 ready", int'(sym_ready), int'(busy_m == 0));
    check(bit_valid == vexp, "R1/R6 valid", int'(bit_valid), int'(vexp));
    if (bit_valid) begin
      nout++;
      e = (expq.size() > 0) ? expq.pop_front() : 1'b0;
      check(bit_out == e, req, int'(bit_out), int'(e));
    end
    sym_valid = v;
    sym = s;
    vexp = (busy_m == 1);
    if (busy_m > 0) busy_m--;
    else if (v) begin
      nacc++;
      if (nacc >= DEPTH) busy_m = DEPTH;
    end
    cycles++;
    if (cycles > 150000) wd = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sym_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    busy_m = 0; nacc = 0; nout = 0; es = 0; vexp = 1'b0;
    expq.delete();
    check(sym_ready == 1'b1, "R1 reset ready", int'(sym_ready), 1);
    check(bit_valid == 1'b0, "R1 reset valid", int'(bit_valid), 0);
  endtask

  // pat: 0 random, 1 all ones, 2 alternating pairs; errp: error spacing (0 none)
  task automatic run(input int nbits, input int pat, input int errp, input string r);
    int k = 0;
    int rr;
    bit u;
    logic [1:0] s;
    req = r;
    while (k < nbits && !wd) begin
      if (busy_m != 0) step(1'b1, 2'($urandom));
      else if ($urandom % 5 == 0) step(1'b0, 2'($urandom));
      else begin
        u = (pat == 0) ? 1'($urandom) : (pat == 1) ? 1'b1 : 1'((k >> 1) & 1);
        rr = (int'(u) << (K - 1)) | es;
        s = {1'($countones(rr & GB)), 1'($countones(rr & GA))};
        if (errp > 0 && (k % errp) == errp / 2) s[k % 2] = ~s[k % 2];
        es = rr >> 1;
        expq.push_back(u);
        step(1'b1, s);
        k++;
      end
    end
    for (int i = 0; i < DEPTH + 3 && !wd; i++) step(1'b0, 2'b00);
    check(nout == nbits - DEPTH + 1, "R5 count", nout, nbits - DEPTH + 1);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    run(120, 0, 0, "R2 random clean");
    do_reset();
    run(90, 1, 0, "R2 all ones");
    do_reset();
    run(90, 2, 40, "R4 alternating errors");
    do_reset();
    run(300, 0, 40, "R4 random errors");
    do_reset();
    run(650, 0, 41, "R3 long stream");
    if (wd) check(1'b0, "watchdog", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule